// File: doc/BRIEF.md
# Indirect Memory Access Register Unit

This block is a register-mapped bridge. A host reaches an internal memory of 64-bit words through four 64-bit registers: address, command, status and data. The host loads a byte address and writes a command word that starts a read or a write. Data then moves through the data register. The status register reports a busy flag and two completion flags. The host can take a lock, which raises busy. A command bit resets the sequencing state.

When auto-increment is on, the data register drives the transfers. Each read of the data register fetches the word at the current address. Each write of the data register stores a word there. After every such transfer the address advances by one word (8 bytes), so a burst runs without the address being rewritten. The step touches only the low 16 address bits, which wrap inside that field. With auto-increment off, writing the command register performs a single transfer.

All bit numbers below count from the most significant end: bit 0 is bit [63] of the 64-bit word and bit n is bit [63-n]. The host bus is word-addressed and has separate read and write strobes. A read returns its value on `host_rdata` two rising edges after the strobe is sampled. A write takes effect at the edge that samples it. If both strobes are high in the same cycle, the write wins and the read is dropped.

Top module: `indirect_mem_bridge`

## Requirements
- R1: After the synchronous reset, the address, command, status and data registers all read as zero, and `host_rdata` is zero.
- R2: The register offsets are 0 for address, 1 for command, 3 for status and 4 for data. Reads of any other offset return zero. Writes to the status register or to unmapped offsets change nothing. A read strobe sampled at edge T shows its value on `host_rdata` after edge T+1.
- R3: A command write with the state-machine reset bit set clears the whole status register. The command bits of that write are stored with bit 2 (start) forced to 0, which cancels any burst in progress. The address register is left unchanged.
- R4: A command write with the lock bit (bit 11) set drives busy (status bit 0) to 1. The exceptions are a write that also resets the state machine, and a write that completes a transfer at once.
- R5: A command write that starts a single read (bit 2 = 1, bit 5 = 1, bits 6, 7 and 19 = 0) loads the word at the current address into the data register one edge later. At that edge it sets address-done (status bit 2) and data-done (status bit 3) and clears busy.
- R6: A command write that starts a single write (bit 2 = 1, bit 5 = 0, bits 6, 7 and 19 = 0) stores the data register at the current address. At the same edge it sets both done flags and clears busy.
- R7: While the held command is a read start with auto-increment (bit 19) on, each data-register read returns the word at the current address and then advances the address by 8.
- R8: While the held command is a write start (bits 6 and 7 clear), each data-register write stores the written value at the current address. The address then advances by 8 when auto-increment is on, and stays put when it is off.
- R9: An address step adds 8 to bits [15:0] of the address register, wrapping modulo 2^16. Bits [63:16] stay unchanged.
- R10: Any data-register access first clears both done flags. It then sets address-done unless the held command is data-only (bit 7), and sets data-done unless it is address-only (bit 6). Busy clears only when both done flags end up set and auto-increment is off. Otherwise busy keeps its value.
- R11: A command that is address-only or data-only never moves a word to or from memory.
- R12: The memory word index is address bits [MEM_AW+2:3]. Bits [2:0] and the bits above the index are ignored for the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Word offset of the register |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data, registered, two edges after the read strobe |

## Verification
The bench targets the following corner cases:
- **Burst across the 16-bit boundary.** The burst starts at low address 0xFFF8. A design that carried into bit 16 would show the wrong upper address, and a design that did not wrap would read back the wrong word on the second transfer.
- **Auto-increment bursts.** A busy flag that dropped during such a burst would show up in the status reads taken between transfers.
- **Address-only and data-only commands.** The bench checks which done flag each one suppresses, and that memory is untouched afterwards: a later read of that word would expose a stray write.
- **State-machine reset mid-burst.** Issuing the reset with the start bit set shows whether start is masked and whether the address is preserved. A design that kept the burst alive would step the address on the next data read.
- **Data read right after a single-read command.** This forces the fetched word to be forwarded. A design that returned the previous data register contents would fail this check.

// File: rtl/imb_pkg.sv
package imb_pkg;
  localparam int REG_W  = 64;
  localparam int OFF_W  = 3;
  localparam int BYTE_SH = $clog2(REG_W / 8);

  localparam logic [OFF_W-1:0] OFF_ADDR = 3'd0;
  localparam logic [OFF_W-1:0] OFF_CMD  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DATA = 3'd4;

  // bit positions, numbered from the MSB end (bit n -> [REG_W-1-n])
  localparam int CB_START = REG_W - 1 - 2;
  localparam int CB_FRST  = REG_W - 1 - 4;
  localparam int CB_RD    = REG_W - 1 - 5;
  localparam int CB_AONLY = REG_W - 1 - 6;
  localparam int CB_DONLY = REG_W - 1 - 7;
  localparam int CB_LOCK  = REG_W - 1 - 11;
  localparam int CB_AINC  = REG_W - 1 - 19;

  localparam int SB_BUSY  = REG_W - 1 - 0;
  localparam int SB_ADONE = REG_W - 1 - 2;
  localparam int SB_DDONE = REG_W - 1 - 3;

  typedef struct packed {
    logic start;
    logic fsm_rst;
    logic rd;
    logic addr_only;
    logic data_only;
    logic lock;
    logic ainc;
  } cmd_t;

  function automatic cmd_t dec_cmd(input logic [REG_W-1:0] w);
    cmd_t c;
    c.start     = w[CB_START];
    c.fsm_rst   = w[CB_FRST];
    c.rd        = w[CB_RD];
    c.addr_only = w[CB_AONLY];
    c.data_only = w[CB_DONLY];
    c.lock      = w[CB_LOCK];
    c.ainc      = w[CB_AINC];
    return c;
  endfunction

  function automatic logic xfer_ok(input cmd_t c);
    return c.start & ~c.addr_only & ~c.data_only;
  endfunction
endpackage

// File: rtl/imb_word_ram.sv
module imb_word_ram #(
  parameter int AW = 8,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // read-first single-port style, suitable for block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/imb_addr_step.sv
module imb_addr_step #(
  parameter int W      = 64,
  parameter int WRAP_W = 16,
  parameter int STEP   = 8
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  generate
    if (WRAP_W >= W) begin : g_full
      localparam logic [W-1:0] INC = W'(STEP);
      assign nxt = cur + INC;
    end else begin : g_wrap
      localparam logic [WRAP_W-1:0] INC = WRAP_W'(STEP);
      logic [WRAP_W-1:0] low_n;
      assign low_n = cur[WRAP_W-1:0] + INC;
      assign nxt   = {cur[W-1:WRAP_W], low_n};
    end
  endgenerate
endmodule

// File: rtl/imb_status.sv
module imb_status (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic set_busy,
  input  logic clr_done,
  input  logic done_evt,
  input  logic ad_set,
  input  logic dd_set,
  input  logic ainc,
  output logic busy,
  output logic ad,
  output logic dd
);
  logic busy_n, ad_n, dd_n;

  always_comb begin
    busy_n = busy;
    ad_n   = ad;
    dd_n   = dd;
    if (clr_done) begin
      ad_n = 1'b0;
      dd_n = 1'b0;
    end
    if (set_busy) busy_n = 1'b1;
    if (done_evt) begin
      ad_n = ad_n | ad_set;
      dd_n = dd_n | dd_set;
      if (ad_n && dd_n && !ainc) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      busy <= 1'b0;
      ad   <= 1'b0;
      dd   <= 1'b0;
    end else begin
      busy <= busy_n;
      ad   <= ad_n;
      dd   <= dd_n;
    end
  end

  // busy only drops on a completion event
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_evt && !clr_all) |=> busy);
endmodule

// File: rtl/indirect_mem_bridge.sv
module indirect_mem_bridge
  import imb_pkg::*;
#(
  parameter int MEM_AW  = 8,
  parameter int WRAP_W  = 16,
  parameter int STEP_B  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [OFF_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata
);
  logic [REG_W-1:0] addr_q, cmd_q, data_q, addr_nxt, ram_q, stat_w, p_val;
  logic             rd_pend, p_mem;
  logic             st_busy, st_ad, st_dd;
  cmd_t             nc, hc;

  logic rd_acc, cmd_wr, data_wr, data_rd, data_acc;
  logic cmd_rd_go, cmd_wr_go, dw_go, dr_go, step, pend_done, fsm_clr;

  assign nc = dec_cmd(host_wdata);
  assign hc = dec_cmd(cmd_q);

  assign rd_acc   = host_rd & ~host_wr;
  assign cmd_wr   = host_wr && (host_addr == OFF_CMD);
  assign data_wr  = host_wr && (host_addr == OFF_DATA);
  assign data_rd  = rd_acc && (host_addr == OFF_DATA);
  assign data_acc = data_wr | data_rd;
  assign fsm_clr  = cmd_wr & nc.fsm_rst;

  assign cmd_rd_go = cmd_wr & ~nc.fsm_rst & xfer_ok(nc) &  nc.rd & ~nc.ainc;
  assign cmd_wr_go = cmd_wr & ~nc.fsm_rst & xfer_ok(nc) & ~nc.rd & ~nc.ainc;
  assign dw_go     = data_wr & xfer_ok(hc) & ~hc.rd;
  assign dr_go     = data_rd & xfer_ok(hc) &  hc.rd & hc.ainc;
  assign step      = (dw_go & hc.ainc) | dr_go;
  assign pend_done = rd_pend & ~fsm_clr;

  imb_addr_step #(.W(REG_W), .WRAP_W(WRAP_W), .STEP(STEP_B)) u_step (
    .cur(addr_q), .nxt(addr_nxt));

  imb_word_ram #(.AW(MEM_AW), .W(REG_W)) u_ram (
    .clk  (clk),
    .we   (cmd_wr_go | dw_go),
    .waddr(addr_q[BYTE_SH +: MEM_AW]),
    .wdata(dw_go ? host_wdata : data_q),
    .raddr(addr_q[BYTE_SH +: MEM_AW]),
    .rdata(ram_q)
  );

  imb_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .clr_all (fsm_clr),
    .set_busy(cmd_wr & nc.lock),
    .clr_done((cmd_wr & nc.start) | data_acc),
    .done_evt(cmd_wr_go | pend_done | data_acc),
    .ad_set  (cmd_wr_go | pend_done | (data_acc & ~hc.data_only)),
    .dd_set  (cmd_wr_go | pend_done | (data_acc & ~hc.addr_only)),
    .ainc    (cmd_wr ? nc.ainc : hc.ainc),
    .busy    (st_busy),
    .ad      (st_ad),
    .dd      (st_dd)
  );

  always_comb begin
    stat_w           = '0;
    stat_w[SB_BUSY]  = st_busy;
    stat_w[SB_ADONE] = st_ad;
    stat_w[SB_DDONE] = st_dd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      cmd_q      <= '0;
      data_q     <= '0;
      rd_pend    <= 1'b0;
      p_mem      <= 1'b0;
      p_val      <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr && host_addr == OFF_ADDR) addr_q <= host_wdata;
      else if (step)                        addr_q <= addr_nxt;

      if (cmd_wr) begin
        cmd_q <= host_wdata;
        if (nc.fsm_rst) cmd_q[CB_START] <= 1'b0;
      end

      if (data_wr)                data_q <= host_wdata;
      else if (pend_done || p_mem) data_q <= ram_q;

      rd_pend <= cmd_rd_go;
      p_mem   <= dr_go | (data_rd & rd_pend);

      p_val <= '0;
      if (rd_acc) begin
        case (host_addr)
          OFF_ADDR: p_val <= addr_q;
          OFF_CMD:  p_val <= cmd_q;
          OFF_STAT: p_val <= stat_w;
          OFF_DATA: p_val <= data_q;
          default:  p_val <= '0;
        endcase
      end
      host_rdata <= p_mem ? ram_q : p_val;
    end
  end

  assert_fsm_reset_clears_R3: assert property (@(posedge clk) disable iff (rst)
    fsm_clr |=> (stat_w == '0));

  assert_fsm_reset_keeps_addr_R3: assert property (@(posedge clk) disable iff (rst)
    fsm_clr |=> (addr_q == $past(addr_q)));

  assert_lock_sets_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && nc.lock && !nc.fsm_rst && !cmd_wr_go && !rd_pend) |=> st_busy);

  assert_read_fills_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && !fsm_clr) |=> (st_ad && st_dd));

  assert_step_wraps_R9: assert property (@(posedge clk) disable iff (rst)
    step |=> (addr_q[WRAP_W-1:0] == WRAP_W'($past(addr_q[WRAP_W-1:0]) + STEP_B)) &&
             (addr_q[REG_W-1:WRAP_W] == $past(addr_q[REG_W-1:WRAP_W])));

  assert_burst_keeps_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (st_busy && hc.ainc && data_acc) |=> st_busy);

  assert_partial_no_move_R11: assert property (@(posedge clk) disable iff (rst)
    (data_acc && (hc.addr_only || hc.data_only)) |=> !p_mem);
endmodule

// File: tb/indirect_mem_bridge_tb.sv
module indirect_mem_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [63:0] got;

  always #5 clk = ~clk;

  indirect_mem_bridge u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  localparam logic [2:0] A = 3'd0, C = 3'd1, S = 3'd3, D = 3'd4;

  typedef struct packed {
    logic        is_rd;
    logic [2:0]  off;
    logic [63:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, A, 64'h10,                  4'd2},
    '{1'b1, A, 64'h10,                  4'd2},
    '{1'b0, D, 64'h1111_2222_3333_4444, 4'd10},
    '{1'b1, S, 64'h3000_0000_0000_0000, 4'd10},
    '{1'b0, C, 64'h2000_0000_0000_0000, 4'd6},
    '{1'b0, A, 64'h18,                  4'd8},
    '{1'b0, D, 64'h5555_6666_7777_8888, 4'd8},
    '{1'b0, C, 64'h0,                   4'd2},
    '{1'b0, D, 64'hDEAD_BEEF_0000_0001, 4'd10},
    '{1'b0, A, 64'h10,                  4'd5},
    '{1'b0, C, 64'h2400_0000_0000_0000, 4'd5},
    '{1'b1, D, 64'h1111_2222_3333_4444, 4'd5},
    '{1'b1, S, 64'h3000_0000_0000_0000, 4'd5},
    '{1'b0, A, 64'h18,                  4'd8},
    '{1'b0, C, 64'h2400_0000_0000_0000, 4'd8},
    '{1'b1, D, 64'h5555_6666_7777_8888, 4'd8},
    '{1'b1, C, 64'h2400_0000_0000_0000, 4'd2},
    '{1'b1, 3'd2, 64'h0,                4'd2},
    '{1'b1, 3'd7, 64'h0,                4'd2}
  };

  task automatic wr(input logic [2:0] o, input logic [63:0] d);
    host_wr = 1'b1; host_addr = o; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [63:0] v);
    host_rd = 1'b1; host_addr = o;
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  localparam logic [63:0] W0 = 64'hCAFE_0000_0000_00F0;
  localparam logic [63:0] W1 = 64'hCAFE_0000_0000_0001;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(host_rdata, 64'h0, "R1 rdata");
    rd(S, got); chk(got, 64'h0, "R1 status");
    rd(A, got); chk(got, 64'h0, "R1 address");
    rd(C, got); chk(got, 64'h0, "R1 command");
    rd(D, got); chk(got, 64'h0, "R1 data");

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_rd) begin
        rd(TBL[i].off, got);
        n_chk++;
        if (got !== TBL[i].val) begin
          n_bad++;
          $display("FAIL R%0d vec %0d: got %h expected %h", TBL[i].req, i, got, TBL[i].val);
        end
      end else begin
        wr(TBL[i].off, TBL[i].val);
      end
    end

    // R3 / R4
    wr(C, 64'h0800_0000_0000_0000);
    rd(S, got); chk(got, 64'h0, "R3 reset clears status");
    wr(C, 64'h0010_0000_0000_0000);
    rd(S, got); chk(got, 64'h8000_0000_0000_0000, "R4 lock busy");
    // R10 busy clears on data access with increment off
    wr(D, 64'h0BAD);
    rd(S, got); chk(got, 64'h3000_0000_0000_0000, "R10 busy clear");
    // R6 single write with lock
    wr(A, 64'h20);
    wr(D, 64'h4444);
    wr(C, 64'h2010_0000_0000_0000);
    rd(S, got); chk(got, 64'h3000_0000_0000_0000, "R6 write done");
    // R11 / R10 partial commands
    wr(C, 64'h2200_0000_0000_0000);
    wr(D, 64'h7777);
    rd(S, got); chk(got, 64'h2000_0000_0000_0000, "R10 addr-only flags");
    wr(C, 64'h2100_0000_0000_0000);
    wr(D, 64'h8888);
    rd(S, got); chk(got, 64'h1000_0000_0000_0000, "R10 data-only flags");
    wr(C, 64'h2400_0000_0000_0000);
    rd(D, got); chk(got, 64'h4444, "R11 memory untouched");
    // R8 / R9 auto-increment write burst across wrap
    wr(A, 64'h0000_0001_0000_FFF8);
    wr(C, 64'h2010_1000_0000_0000);
    rd(S, got); chk(got, 64'h8000_0000_0000_0000, "R4 lock with burst start");
    wr(D, W0);
    rd(S, got); chk(got, 64'hB000_0000_0000_0000, "R10 busy held in burst");
    wr(D, W1);
    rd(A, got); chk(got, 64'h0000_0001_0000_0008, "R9 wrap");
    // R7 auto-increment read burst
    wr(A, 64'h0000_0001_0000_FFF8);
    wr(C, 64'h2400_1000_0000_0000);
    rd(D, got); chk(got, W0, "R7 first word");
    rd(D, got); chk(got, W1, "R7 second word");
    rd(A, got); chk(got, 64'h0000_0001_0000_0008, "R7 address stepped");
    rd(S, got); chk(got, 64'hB000_0000_0000_0000, "R10 busy held in read burst");
    // R3 reset mid-burst with start set
    wr(C, 64'h2C00_1000_0000_0000);
    rd(S, got); chk(got, 64'h0, "R3 status cleared");
    rd(C, got); chk(got, 64'h0C00_1000_0000_0000, "R3 start masked");
    rd(D, got); chk(got, W1, "R3 no fetch");
    rd(A, got); chk(got, 64'h0000_0001_0000_0008, "R3 address kept");
    // R12 index bits
    wr(A, 64'h807);
    wr(C, 64'h2400_0000_0000_0000);
    rd(D, got); chk(got, W1, "R12 index");
    // R2 read-only status and unmapped write
    wr(S, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(S, got); chk(got, 64'h3000_0000_0000_0000, "R2 status read-only");
    wr(3'd5, 64'hFF);
    rd(3'd5, got); chk(got, 64'h0, "R2 unmapped");
    // R5 data read right after the read command
    wr(A, 64'h10);
    wr(C, 64'h2400_0000_0000_0000);
    rd(D, got); chk(got, 64'h1111_2222_3333_4444, "R5 forwarded read");
    finish_run();
  end
endmodule